// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block is the reset-entry controller of a small 32-bit processor front end. While the synchronous active-low reset is held, it parks every piece of entry state at a fixed default: no memory request, program counter and stack pointer at their reset values, privileged mode on and interrupts off. It also samples a strap that picks the low or the high default table base.

Once reset is released, it walks a two-word vector table through a single-outstanding read port. The first word becomes the initial stack pointer and the second becomes the entry address. It then hands both values to the core with a one-cycle start strobe. A relocation register, writable at any time outside reset and kept 128-byte aligned, can override the strapped table base.

A handler address that is zero, all ones or not word aligned is replaced by a fixed error-handler address. The same replacement happens after a bus error on either read. A fresh reset at any point abandons the walk, and the walk then begins again from the first word.

Top module: `rstvec_sequencer`

## Requirements
- R1: In the cycle after any clock edge that samples rst_n low: mem_req, core_start and core_run are 0, core_pc and core_sp are 0x00000000, reloc_value is 0, core_priv is 1 and core_irq_en is 0.
- R2: cfg_hi_base is sampled while rst_n is low. If the relocation register is zero when the walk begins, the table base is 0x00000000 when the sample was 0 and 0xFFFF0000 when it was 1.
- R3: A reloc_we pulse stores reloc_wdata with bits [6:0] cleared, and reloc_value shows the result from the next cycle. A nonzero stored value is the table base of a walk that begins after it. A write on the same edge that leaves reset already counts.
- R4: In the first cycle after reset is released, mem_req rises with mem_addr equal to the table base. After that read completes (mem_req and mem_ack both high at an edge), mem_addr becomes base+4. mem_req and mem_addr hold steady until mem_ack. mem_addr is zero whenever mem_req is low.
- R5: core_sp takes the data of the first read.
- R6: core_pc takes the data of the second read when that value is valid and no bus error occurred.
- R7: A handler value of 0x00000000, 0xFFFFFFFF, or with bits [1:0] nonzero loads core_pc with 0x00000200 instead.
- R8: mem_err high with mem_ack on either read loads core_pc with 0x00000200.
- R9: core_start is high for exactly the one cycle after the second read completes. From the following cycle core_run stays high until reset.
- R10: Reset during the walk drops the request at once, with no start strobe. This holds even when the second read completes on the same edge. After release, the walk restarts from base+0.
- R11: At the start strobe core_priv is 1 and core_irq_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hi_base | input | 1 | Strap for the high default table base, sampled in reset |
| reloc_we | input | 1 | Write strobe of the relocation register |
| reloc_wdata | input | 32 | Relocation write value |
| reloc_value | output | 32 | Stored relocation value (bits [6:0] zero) |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Read address |
| mem_ack | input | 1 | Read completes in a cycle with mem_req high |
| mem_err | input | 1 | Bus error qualifier of mem_ack |
| mem_rdata | input | 32 | Read data qualifier of mem_ack |
| core_start | output | 1 | One-cycle hand-over strobe |
| core_run | output | 1 | High after hand-over until reset |
| core_pc | output | 32 | Program counter handed to the core |
| core_sp | output | 32 | Stack pointer handed to the core |
| core_priv | output | 1 | Privileged mode at hand-over |
| core_irq_en | output | 1 | Maskable interrupt enable at hand-over |

## Verification
Two events can share one clock edge. Reset can return on the edge where the second read completes, and a relocation write can land on the edge that leaves reset. For the first case, the bench watches for the cycle where mem_ack is high on the base+4 read and pulls rst_n low in that same cycle. It then expects no start strobe, a dropped request, and a complete walk from base+0 after release. For the second case, the write is issued with the release, and the first read address must already carry the aligned new base. A behavioural reference model predicts every output on every clock, and literal end values confirm each walk.

// File: rtl/rvf_pkg.sv
// Shared types of the reset vector fetch sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package rvf_pkg;

    // Walk phases: parked in reset, first word, second word, hand-over, running.
    typedef enum logic [2:0] {
        ST_RST = 3'd0,
        ST_SP  = 3'd1,
        ST_PC  = 3'd2,
        ST_GO  = 3'd3,
        ST_RUN = 3'd4
    } rvf_state_e;

endpackage

// File: rtl/rvf_base_sel.sv
// Table base selection: samples the high/low strap during reset, holds the
// aligned relocation register and freezes the base used by one walk.
// Assumes: launch is high only in the single cycle before the first read.
module rvf_base_sel #(
    parameter int              W          = 32,
    parameter int              ALIGN_BITS = 7,
    parameter logic [W-1:0]    LOW_BASE   = '0,
    parameter logic [W-1:0]    HIGH_BASE  = 32'hFFFF_0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_hi,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         launch,
    output logic [W-1:0] reloc_q,
    output logic [W-1:0] base_q
);
    localparam logic [W-1:0] ONE        = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ALIGN_MASK = ~((ONE << ALIGN_BITS) - ONE);

    logic         hi_q;
    logic [W-1:0] reloc_next;

    // Value the relocation register holds after this edge.
    always_comb reloc_next = wr_en ? (wr_data & ALIGN_MASK) : reloc_q;

    // Strap capture: follows the pin only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= cfg_hi;
    end

    // Relocation register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) reloc_q <= '0;
        else        reloc_q <= reloc_next;
    end

    // Base of the walk, fixed on the edge that leaves the parked state.
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (launch) base_q <= (reloc_next != '0) ? reloc_next
                                                      : (hi_q ? HIGH_BASE : LOW_BASE);
    end
endmodule

// File: rtl/rvf_fetch_ctl.sv
// Walk controller: issues the two ordered reads one at a time, then the
// hand-over strobe, then parks in the running state until reset.
// Assumes: the memory completes a read in a cycle where mem_req is high.
module rvf_fetch_ctl
    import rvf_pkg::*;
#(
    parameter int W          = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] base,
    input  logic         mem_ack,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    output logic         launch,
    output logic         sp_done,
    output logic         pc_done,
    output logic         start,
    output logic         run
);
    localparam logic [W-1:0] PC_OFS = W'(WORD_BYTES);

    rvf_state_e state_q, state_d;

    // Phase register; reset abandons whatever phase was active.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RST;
        else        state_q <= state_d;
    end

    // Phase order: park, stack word, entry word, strobe, run.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST: state_d = ST_SP;
            ST_SP:  if (mem_ack) state_d = ST_PC;
            ST_PC:  if (mem_ack) state_d = ST_GO;
            ST_GO:  state_d = ST_RUN;
            ST_RUN: state_d = ST_RUN;
            default: state_d = ST_RST;
        endcase
    end

    // Read port and phase strobes decoded from the phase.
    always_comb begin
        mem_req  = (state_q == ST_SP) || (state_q == ST_PC);
        mem_addr = (state_q == ST_SP) ? base
                 : (state_q == ST_PC) ? base + PC_OFS : '0;
        launch   = (state_q == ST_RST);
        sp_done  = (state_q == ST_SP) && mem_ack;
        pc_done  = (state_q == ST_PC) && mem_ack;
        start    = (state_q == ST_GO);
        run      = (state_q == ST_RUN);
    end
endmodule

// File: rtl/rvf_vec_check.sv
// Entry address screening: replaces a zero, all-ones or misaligned value, or
// one tainted by a bus error, with the fixed error-handler address.
// Assumes: ERR_PC itself passes the same screening.
module rvf_vec_check #(
    parameter int           W          = 32,
    parameter int           INSN_ALIGN = 2,
    parameter logic [W-1:0] ERR_PC     = 32'h0000_0200
) (
    input  logic [W-1:0] value,
    input  logic         bus_err,
    input  logic         prior_err,
    output logic         bad,
    output logic [W-1:0] pc_out
);
    logic misaligned;

    // Alignment screen: width picked by INSN_ALIGN, none when it is zero.
    generate
        if (INSN_ALIGN > 0) begin : g_align
            always_comb misaligned = |value[INSN_ALIGN-1:0];
        end else begin : g_noalign
            always_comb misaligned = 1'b0;
        end
    endgenerate

    // Verdict and substituted address.
    always_comb begin
        bad    = bus_err || prior_err || (value == '0) || (&value) || misaligned;
        pc_out = bad ? ERR_PC : value;
    end
endmodule

// File: rtl/rvf_vec_regs.sv
// Hand-over registers: stack pointer, program counter, privilege and
// interrupt-enable state, all forced to defaults during reset.
// Assumes: sp_done precedes pc_done within one walk.
module rvf_vec_regs #(
    parameter int           W          = 32,
    parameter int           INSN_ALIGN = 2,
    parameter logic [W-1:0] RESET_PC   = '0,
    parameter logic [W-1:0] ERR_PC     = 32'h0000_0200
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sp_done,
    input  logic         pc_done,
    input  logic [W-1:0] rdata,
    input  logic         rerr,
    output logic [W-1:0] sp_q,
    output logic [W-1:0] pc_q,
    output logic         priv_q,
    output logic         irq_en_q
);
    logic         sp_err_q;
    logic         pc_bad;
    logic [W-1:0] pc_next;

    rvf_vec_check #(
        .W(W), .INSN_ALIGN(INSN_ALIGN), .ERR_PC(ERR_PC)
    ) u_check (
        .value    (rdata),
        .bus_err  (rerr),
        .prior_err(sp_err_q),
        .bad      (pc_bad),
        .pc_out   (pc_next)
    );

    // Stack word capture plus its bus error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q     <= '0;
            sp_err_q <= 1'b0;
        end else if (sp_done) begin
            sp_q     <= rdata;
            sp_err_q <= rerr;
        end
    end

    // Entry address capture through the screen.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= RESET_PC;
        else if (pc_done) pc_q <= pc_next;
    end

    // Mode defaults; owned by the core once it runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q   <= 1'b1;
            irq_en_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rstvec_sequencer.sv
// Reset vector fetch sequencer top: joins base selection, walk control and
// hand-over registers. Reset is synchronous and active low.
// Assumes: one read outstanding; no address translation on the read port.
module rstvec_sequencer #(
    parameter int           W          = 32,
    parameter int           WORD_BYTES = 4,
    parameter int           ALIGN_BITS = 7,
    parameter int           INSN_ALIGN = 2,
    parameter logic [W-1:0] LOW_BASE   = 32'h0000_0000,
    parameter logic [W-1:0] HIGH_BASE  = 32'hFFFF_0000,
    parameter logic [W-1:0] RESET_PC   = 32'h0000_0000,
    parameter logic [W-1:0] ERR_PC     = 32'h0000_0200
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_hi_base,
    input  logic         reloc_we,
    input  logic [W-1:0] reloc_wdata,
    output logic [W-1:0] reloc_value,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    input  logic         mem_ack,
    input  logic         mem_err,
    input  logic [W-1:0] mem_rdata,
    output logic         core_start,
    output logic         core_run,
    output logic [W-1:0] core_pc,
    output logic [W-1:0] core_sp,
    output logic         core_priv,
    output logic         core_irq_en
);
    logic [W-1:0] base;
    logic         launch;
    logic         sp_done;
    logic         pc_done;

    rvf_base_sel #(
        .W(W), .ALIGN_BITS(ALIGN_BITS), .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE)
    ) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_hi (cfg_hi_base),
        .wr_en  (reloc_we),
        .wr_data(reloc_wdata),
        .launch (launch),
        .reloc_q(reloc_value),
        .base_q (base)
    );

    rvf_fetch_ctl #(
        .W(W), .WORD_BYTES(WORD_BYTES)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (base),
        .mem_ack (mem_ack),
        .mem_req (mem_req),
        .mem_addr(mem_addr),
        .launch  (launch),
        .sp_done (sp_done),
        .pc_done (pc_done),
        .start   (core_start),
        .run     (core_run)
    );

    rvf_vec_regs #(
        .W(W), .INSN_ALIGN(INSN_ALIGN), .RESET_PC(RESET_PC), .ERR_PC(ERR_PC)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sp_done (sp_done),
        .pc_done (pc_done),
        .rdata   (mem_rdata),
        .rerr    (mem_err),
        .sp_q    (core_sp),
        .pc_q    (core_pc),
        .priv_q  (core_priv),
        .irq_en_q(core_irq_en)
    );
endmodule

// File: rtl/rvf_seq_chk.sv
// Protocol checker for the reset vector fetch sequencer, bound to the top.
// Assumes: table bases are at least 8-byte aligned, so bit 2 marks the
// second word.
module rvf_seq_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mem_req,
    input logic [W-1:0] mem_addr,
    input logic         mem_ack,
    input logic         core_start,
    input logic         core_run,
    input logic [W-1:0] core_pc,
    input logic         core_priv,
    input logic         core_irq_en
);
    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R4
    first_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> mem_req);

    // R1
    reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_req && !core_start && !core_run));

    // R9
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> (!core_start && core_run));

    // R9
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> $past(mem_req && mem_ack && mem_addr[2]));

    // R7
    pc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (core_pc != '0 && core_pc != '1 && core_pc[1:0] == 2'b00));

    // R11
    mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (core_priv && !core_irq_en));
endmodule

bind rstvec_sequencer rvf_seq_chk #(.W(W)) u_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .core_start (core_start),
    .core_run   (core_run),
    .core_pc    (core_pc),
    .core_priv  (core_priv),
    .core_irq_en(core_irq_en)
);

// File: tb/rstvec_sequencer_test.sv
module rstvec_sequencer_test;
    localparam logic [31:0] HI_BASE = 32'hFFFF_0000;
    localparam logic [31:0] ERRPC   = 32'h0000_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_hi_base = 1'b0;
    logic        reloc_we = 1'b0;
    logic [31:0] reloc_wdata = '0;
    logic [31:0] reloc_value;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        core_start, core_run, core_priv, core_irq_en;
    logic [31:0] core_pc, core_sp;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    // scenario memory contents
    logic [31:0] sc_base = '0, sc_sp = '0, sc_pc = '0;
    logic        sc_esp = 1'b0, sc_epc = 1'b0;
    int          sc_lat = 0;
    int          wcnt = 0;

    always #2 clk = ~clk;

    rstvec_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cfg_hi_base(cfg_hi_base),
        .reloc_we(reloc_we), .reloc_wdata(reloc_wdata), .reloc_value(reloc_value),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata),
        .core_start(core_start), .core_run(core_run), .core_pc(core_pc),
        .core_sp(core_sp), .core_priv(core_priv), .core_irq_en(core_irq_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic vec_bad(input logic [31:0] v);
        return (v == 32'h0) || (v == 32'hFFFF_FFFF) || (v[1:0] != 2'b00);
    endfunction

    // ---------------- reference model, stepped at each rising edge ----------
    int          m_ph = 0;   // 0 parked, 1 first word, 2 second word, 3 strobe, 4 run
    logic [31:0] m_base = '0, m_reloc = '0, m_sp = '0, m_pc = '0;
    logic        m_hi = 1'b0, m_sperr = 1'b0;

    always @(posedge clk) begin
        logic [31:0] nreloc;
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_reloc = '0; m_hi = cfg_hi_base;
            m_sp = '0; m_pc = '0; m_sperr = 1'b0;
        end else begin
            nreloc = reloc_we ? {reloc_wdata[31:7], 7'b0} : m_reloc;
            if (m_ph == 0) begin
                m_base = (nreloc != 0) ? nreloc : (m_hi ? HI_BASE : 32'h0);
                m_ph = 1;
            end else if (m_ph == 1) begin
                if (mem_ack) begin m_sp = mem_rdata; m_sperr = mem_err; m_ph = 2; end
            end else if (m_ph == 2) begin
                if (mem_ack) begin
                    m_pc = (mem_err || m_sperr || vec_bad(mem_rdata)) ? ERRPC : mem_rdata;
                    m_ph = 3;
                end
            end else if (m_ph == 3) begin
                m_ph = 4;
            end
            m_reloc = nreloc;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cyc >= 1) begin
            chk("R4 mem_req", {31'b0, mem_req}, {31'b0, (m_ph == 1 || m_ph == 2)});
            chk("R4 mem_addr", mem_addr, (m_ph == 1) ? m_base : (m_ph == 2) ? m_base + 4 : 32'h0);
            chk("R9 core_start", {31'b0, core_start}, {31'b0, m_ph == 3});
            chk("R9 core_run", {31'b0, core_run}, {31'b0, m_ph == 4});
            chk("R6 core_pc", core_pc, m_pc);
            chk("R5 core_sp", core_sp, m_sp);
            chk("R3 reloc_value", reloc_value, m_reloc);
            chk("R11 mode", {30'b0, core_priv, core_irq_en}, 32'h2);
        end
    end

    // memory responder: acknowledges after sc_lat waiting cycles
    always @(negedge clk) begin
        if (!mem_req || mem_ack) begin
            mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0; wcnt = 0;
        end else if (wcnt >= sc_lat) begin
            mem_ack <= 1'b1;
            if (mem_addr == sc_base) begin
                mem_rdata <= sc_sp; mem_err <= sc_esp;
            end else if (mem_addr == sc_base + 4) begin
                mem_rdata <= sc_pc; mem_err <= sc_epc;
            end else begin
                mem_rdata <= 32'hBAD0_BAD0; mem_err <= 1'b1;
            end
        end else begin
            wcnt++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R9 watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic enter_reset(input logic hi);
        @(negedge clk); #1;
        rst_n = 1'b0; cfg_hi_base = hi;
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic release_reset(input logic we, input logic [31:0] wv);
        rst_n = 1'b1; reloc_we = we; reloc_wdata = wv;
        @(negedge clk); #1;
        reloc_we = 1'b0;
    endtask

    task automatic wait_run(input string tag);
        int k;
        for (k = 0; k < 80 && !core_run; k++) begin
            @(negedge clk); #1;
        end
        chk(tag, {31'b0, core_run}, 32'h1);
    endtask

    task automatic walk(input logic hi, input logic we, input logic [31:0] wv,
                        input logic [31:0] base, input logic [31:0] sp,
                        input logic [31:0] pc, input logic esp, input logic epc,
                        input int lat, input logic [31:0] exp_pc, input string tag);
        enter_reset(hi);
        sc_base = base; sc_sp = sp; sc_pc = pc; sc_esp = esp; sc_epc = epc; sc_lat = lat;
        release_reset(we, wv);
        wait_run({tag, " reached run"});
        chk({tag, " final pc"}, core_pc, exp_pc);
        chk({tag, " final sp"}, core_sp, sp);
    endtask

    initial begin
        // R1: state while reset is held
        repeat (4) @(negedge clk);
        #1;
        chk("R1 req in reset", {31'b0, mem_req}, 32'h0);
        chk("R1 pc in reset", core_pc, 32'h0);
        chk("R1 run in reset", {31'b0, core_run}, 32'h0);

        // R2 low base, R5/R6 normal walk
        walk(1'b0, 1'b0, 32'h0, 32'h0000_0000, 32'h2000_0400, 32'h0000_0800, 1'b0, 1'b0, 2, 32'h0000_0800, "R6 low");
        // R2 high base, zero latency
        walk(1'b1, 1'b0, 32'h0, HI_BASE, 32'h1000_0000, 32'h0000_1234, 1'b0, 1'b0, 0, 32'h0000_1234, "R2 high");
        // R3 relocation written on the release edge, low bits dropped
        walk(1'b1, 1'b1, 32'h0000_4FFF, 32'h0000_4F80, 32'h3000_0000, 32'h0004_0000, 1'b0, 1'b0, 1, 32'h0004_0000, "R3 reloc");
        // R7 invalid handler values
        walk(1'b0, 1'b0, 32'h0, 32'h0, 32'h2000_0000, 32'h0000_0000, 1'b0, 1'b0, 1, ERRPC, "R7 zero");
        walk(1'b0, 1'b0, 32'h0, 32'h0, 32'h2000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 0, ERRPC, "R7 ones");
        walk(1'b0, 1'b0, 32'h0, 32'h0, 32'h2000_0000, 32'h0000_1002, 1'b0, 1'b0, 3, ERRPC, "R7 misaligned");
        // R8 bus errors on either read
        walk(1'b0, 1'b0, 32'h0, 32'h0, 32'h2000_0000, 32'h0000_0800, 1'b1, 1'b0, 1, ERRPC, "R8 first read");
        walk(1'b1, 1'b0, 32'h0, HI_BASE, 32'h2000_0000, 32'h0000_0800, 1'b0, 1'b1, 1, ERRPC, "R8 second read");

        // R10 reset while the second read waits
        enter_reset(1'b0);
        sc_base = 32'h0; sc_sp = 32'h2000_0100; sc_pc = 32'h0000_0C00;
        sc_esp = 1'b0; sc_epc = 1'b0; sc_lat = 4;
        release_reset(1'b0, 32'h0);
        for (int k = 0; k < 20 && mem_addr != 32'h4; k++) begin @(negedge clk); #1; end
        chk("R10 in second read", mem_addr, 32'h4);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R10 abort drops req", {31'b0, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R10 restart at base+0", mem_addr, 32'h0);
        wait_run("R10 restart reaches run");
        chk("R10 pc after restart", core_pc, 32'h0000_0C00);

        // R10 reset on the same edge as the second read completing
        enter_reset(1'b1);
        sc_base = HI_BASE; sc_sp = 32'h2000_0200; sc_pc = 32'h0000_0E00; sc_lat = 1;
        release_reset(1'b0, 32'h0);
        for (int k = 0; k < 20 && !(mem_ack && mem_addr == HI_BASE + 4); k++) begin @(negedge clk); #1; end
        chk("R10 ack on second word", {31'b0, mem_ack}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R10 no strobe under reset", {31'b0, core_start}, 32'h0);
        chk("R10 pc stays default", core_pc, 32'h0);
        rst_n = 1'b1;
        wait_run("R10 same-edge restart");
        chk("R10 pc after same-edge restart", core_pc, 32'h0000_0E00);

        // R3 write while running, readback aligned; R1 reset clears it
        reloc_we = 1'b1; reloc_wdata = 32'h1234_56FF;
        @(negedge clk); #1;
        reloc_we = 1'b0;
        chk("R3 readback", reloc_value, 32'h1234_5680);
        chk("R3 write leaves pc", core_pc, 32'h0000_0E00);
        walk(1'b0, 1'b0, 32'h0, 32'h0, 32'h2000_0800, 32'h0000_0900, 1'b0, 1'b0, 1, 32'h0000_0900, "R1 reloc cleared");
        chk("R1 reloc after reset", reloc_value, 32'h0);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule